// File: doc/BRIEF.md
# Segmented Address Mapping Unit

This block turns a logical address into a physical byte address. A logical address has two parts: a segment number that selects one of sixteen descriptor registers, and a 16-bit byte offset within that segment. Each descriptor holds a base and a bound, both counted in 16-byte units, plus enable bits for read, write and execute and a bit that sets when a rights fault is reported. A request also carries an access kind. In the same cycle the block returns either a granted access with its physical address or a trap. A trap has a code, a timing class, the segment number and the access kind.

Two write paths fill the descriptors. A single-register port is used for general setup. A paired port loads two descriptors at once when a procedure is entered, one for its dynamic local area and one for its static local area. A local area can allow writes even when the segment that encloses it does not. A rights fault is reported in one of two ways, chosen per descriptor. In pre-trap mode the access is blocked and the trap appears in the same cycle. In post-trap mode the access is allowed to complete and the trap is reported one cycle later.

Top module: `seg_map_unit`

## Requirements
- R1: After reset every descriptor reads as all zeros and no access is granted or trapped while no request is presented. A request to a cleared descriptor (bound 0, no rights, pre-trap mode) at offsets 0..15 therefore gets a pre-trap with code 2.
- R2: A granted access raises acc_valid_o. phys_addr_o then equals (base << 4) + offset, truncated to 20 bits. The base is descriptor bits [15:0].
- R3: When offset[15:4] is greater than the bound field (descriptor bits [27:16]), the block raises a pre-trap with code 1 and blocks the access. This holds whatever the rights and the trap mode are. An offset whose offset[15:4] equals the bound is in range.
- R4: Access kind 0 (read) needs descriptor bit 28, kind 1 (write) needs bit 29, and kind 2 (execute) needs bit 30. Kind 3 never has the right.
- R5: When descriptor bit 31 is 0, a missing right blocks the access. In the same cycle trap_valid_o rises with code 2 and class trap_post_o=0, and the trap carries the request's segment and kind.
- R6: When descriptor bit 31 is 1, a missing right still grants the access in that cycle. In the next cycle trap_valid_o rises with code 2 and trap_post_o=1, and the trap carries the segment and kind of the faulting access.
- R7: A pre-trap owns the trap outputs in its cycle. A post-trap that is due in that cycle is held and reported in the first later cycle that has no pre-trap.
- R8: The single load port (ld_en_i) writes ld_data_i into descriptor ld_idx_i at the clock edge. A translation in the same cycle uses the old value.
- R9: The procedure-entry load (pe_en_i) writes both descriptors at the same edge. A same-cycle translation sees neither new value, and a single load in that cycle is ignored. If both indices are equal, the second pair (b) wins.
- R10: With req_valid_i low the block grants no access and raises no pre-trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_en_i | input | 1 | Single descriptor load strobe |
| ld_idx_i | input | 4 | Descriptor index for single load |
| ld_data_i | input | 32 | Descriptor value for single load |
| pe_en_i | input | 1 | Procedure-entry paired load strobe |
| pe_idx_a_i | input | 4 | First paired load index |
| pe_data_a_i | input | 32 | First paired load value |
| pe_idx_b_i | input | 4 | Second paired load index (wins on equal index) |
| pe_data_b_i | input | 32 | Second paired load value |
| req_valid_i | input | 1 | Translation request present |
| req_seg_i | input | 4 | Segment number |
| req_off_i | input | 16 | Byte offset |
| req_kind_i | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| acc_valid_o | output | 1 | Access granted |
| phys_addr_o | output | 20 | Physical byte address |
| trap_valid_o | output | 1 | Trap reported this cycle |
| trap_code_o | output | 2 | 1 bound violation, 2 rights violation |
| trap_post_o | output | 1 | Timing class: 0 pre-trap, 1 post-trap |
| trap_seg_o | output | 4 | Segment of the trapping access |
| trap_kind_o | output | 2 | Kind of the trapping access |

## Verification
The hardest state to reach from the ports is a post-trap that is waiting while a pre-trap arrives. Reaching it needs a post-mode rights fault in one cycle, directly followed by a pre-mode fault on a different segment. The next idle cycle must then show the deferred trap with the older segment and kind. The loads that happen in the same cycle as a translation are driven together with the request, and the output is sampled before the clock edge, so the old descriptor values are the ones observed. Reads in the following cycles then show the new ones.

// File: rtl/seg_map_pkg.sv
package seg_map_pkg;
  localparam int OFF_W  = 16;
  localparam int GRAN_W = 4;
  localparam int BASE_W = 16;
  localparam int BND_W  = OFF_W - GRAN_W;
  localparam int PA_W   = BASE_W + GRAN_W;
  localparam int DESC_W = 4 + BND_W + BASE_W;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    TRAP_NONE  = 2'd0,
    TRAP_BOUND = 2'd1,
    TRAP_RIGHT = 2'd2
  } trap_code_e;

  typedef struct packed {
    logic              post_mode;
    logic              x_en;
    logic              w_en;
    logic              r_en;
    logic [BND_W-1:0]  bound;
    logic [BASE_W-1:0] base;
  } seg_desc_t;
endpackage

// File: rtl/seg_desc_file.sv
module seg_desc_file
  import seg_map_pkg::*;
#(
  parameter int NSEG  = 16,
  parameter int IDX_W = $clog2(NSEG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_en_i,
  input  logic [IDX_W-1:0]  ld_idx_i,
  input  logic [DESC_W-1:0] ld_data_i,
  input  logic              pe_en_i,
  input  logic [IDX_W-1:0]  pe_idx_a_i,
  input  logic [DESC_W-1:0] pe_data_a_i,
  input  logic [IDX_W-1:0]  pe_idx_b_i,
  input  logic [DESC_W-1:0] pe_data_b_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output seg_desc_t         rd_desc_o
);
  logic [DESC_W-1:0] regs_q [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[g] <= '0;
      end else if (pe_en_i) begin
        // paired load blocks the single port; pair b wins on equal index
        if (pe_idx_b_i == IDX_W'(g))      regs_q[g] <= pe_data_b_i;
        else if (pe_idx_a_i == IDX_W'(g)) regs_q[g] <= pe_data_a_i;
      end else if (ld_en_i && ld_idx_i == IDX_W'(g)) begin
        regs_q[g] <= ld_data_i;
      end
    end
  end

  assign rd_desc_o = seg_desc_t'(regs_q[rd_idx_i]);

  assert_pe_atomic_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_en_i |=> (regs_q[$past(pe_idx_b_i)] == $past(pe_data_b_i)));
  assert_pe_pair_a_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pe_en_i && pe_idx_a_i != pe_idx_b_i) |=> (regs_q[$past(pe_idx_a_i)] == $past(pe_data_a_i)));
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_map_pkg::*;
(
  input  logic             valid_i,
  input  seg_desc_t        desc_i,
  input  logic [OFF_W-1:0] off_i,
  input  acc_kind_e        kind_i,
  output logic             grant_o,
  output logic [PA_W-1:0]  phys_o,
  output logic             pre_fault_o,
  output trap_code_e       pre_code_o,
  output logic             post_fault_o
);
  logic bound_bad;
  logic right_ok;

  assign bound_bad = off_i[OFF_W-1:GRAN_W] > desc_i.bound;
  assign phys_o    = {desc_i.base, {GRAN_W{1'b0}}} + PA_W'(off_i);

  always_comb begin
    unique case (kind_i)
      ACC_READ:  right_ok = desc_i.r_en;
      ACC_WRITE: right_ok = desc_i.w_en;
      ACC_EXEC:  right_ok = desc_i.x_en;
      default:   right_ok = 1'b0;
    endcase
  end

  always_comb begin
    grant_o      = 1'b0;
    pre_fault_o  = 1'b0;
    pre_code_o   = TRAP_NONE;
    post_fault_o = 1'b0;
    if (valid_i) begin
      if (bound_bad) begin
        pre_fault_o = 1'b1;
        pre_code_o  = TRAP_BOUND;
      end else if (!right_ok && !desc_i.post_mode) begin
        pre_fault_o = 1'b1;
        pre_code_o  = TRAP_RIGHT;
      end else begin
        grant_o      = 1'b1;
        post_fault_o = !right_ok;
      end
    end
  end
endmodule

// File: rtl/seg_trap_stage.sv
module seg_trap_stage
  import seg_map_pkg::*;
#(
  parameter int SEG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pre_fault_i,
  input  trap_code_e       pre_code_i,
  input  logic             post_fault_i,
  input  logic [SEG_W-1:0] cur_seg_i,
  input  acc_kind_e        cur_kind_i,
  output logic             trap_valid_o,
  output trap_code_e       trap_code_o,
  output logic             trap_post_o,
  output logic [SEG_W-1:0] trap_seg_o,
  output acc_kind_e        trap_kind_o
);
  logic             pend_q;
  logic [SEG_W-1:0] pend_seg_q;
  acc_kind_e        pend_kind_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_seg_q  <= '0;
      pend_kind_q <= ACC_READ;
    end else if (post_fault_i) begin
      pend_q      <= 1'b1;
      pend_seg_q  <= cur_seg_i;
      pend_kind_q <= cur_kind_i;
    end else if (pend_q && !pre_fault_i) begin
      pend_q <= 1'b0;
    end
  end

  always_comb begin
    trap_valid_o = 1'b0;
    trap_code_o  = TRAP_NONE;
    trap_post_o  = 1'b0;
    trap_seg_o   = cur_seg_i;
    trap_kind_o  = cur_kind_i;
    if (pre_fault_i) begin
      trap_valid_o = 1'b1;
      trap_code_o  = pre_code_i;
    end else if (pend_q) begin
      trap_valid_o = 1'b1;
      trap_code_o  = TRAP_RIGHT;
      trap_post_o  = 1'b1;
      trap_seg_o   = pend_seg_q;
      trap_kind_o  = pend_kind_q;
    end
  end

  assert_post_late_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_fault_i |=> (pend_q && pend_seg_q == $past(cur_seg_i)));
  assert_defer_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && pre_fault_i) |=> pend_q && $stable(pend_seg_q));
endmodule

// File: rtl/seg_map_unit.sv
module seg_map_unit
  import seg_map_pkg::*;
#(
  parameter int NSEG = 16,
  localparam int SEG_W = $clog2(NSEG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_en_i,
  input  logic [SEG_W-1:0]  ld_idx_i,
  input  logic [DESC_W-1:0] ld_data_i,
  input  logic              pe_en_i,
  input  logic [SEG_W-1:0]  pe_idx_a_i,
  input  logic [DESC_W-1:0] pe_data_a_i,
  input  logic [SEG_W-1:0]  pe_idx_b_i,
  input  logic [DESC_W-1:0] pe_data_b_i,
  input  logic              req_valid_i,
  input  logic [SEG_W-1:0]  req_seg_i,
  input  logic [OFF_W-1:0]  req_off_i,
  input  logic [1:0]        req_kind_i,
  output logic              acc_valid_o,
  output logic [PA_W-1:0]   phys_addr_o,
  output logic              trap_valid_o,
  output logic [1:0]        trap_code_o,
  output logic              trap_post_o,
  output logic [SEG_W-1:0]  trap_seg_o,
  output logic [1:0]        trap_kind_o
);
  seg_desc_t  desc;
  acc_kind_e  kind;
  logic       pre_fault;
  trap_code_e pre_code;
  logic       post_fault;
  trap_code_e code_e;
  acc_kind_e  tkind_e;

  assign kind = acc_kind_e'(req_kind_i);

  seg_desc_file #(.NSEG(NSEG), .IDX_W(SEG_W)) u_desc (
    .clk_i, .rst_ni, .ld_en_i, .ld_idx_i, .ld_data_i,
    .pe_en_i, .pe_idx_a_i, .pe_data_a_i, .pe_idx_b_i, .pe_data_b_i,
    .rd_idx_i (req_seg_i),
    .rd_desc_o(desc)
  );

  seg_xlate u_xlate (
    .valid_i     (req_valid_i),
    .desc_i      (desc),
    .off_i       (req_off_i),
    .kind_i      (kind),
    .grant_o     (acc_valid_o),
    .phys_o      (phys_addr_o),
    .pre_fault_o (pre_fault),
    .pre_code_o  (pre_code),
    .post_fault_o(post_fault)
  );

  seg_trap_stage #(.SEG_W(SEG_W)) u_trap (
    .clk_i, .rst_ni,
    .pre_fault_i (pre_fault),
    .pre_code_i  (pre_code),
    .post_fault_i(post_fault),
    .cur_seg_i   (req_seg_i),
    .cur_kind_i  (kind),
    .trap_valid_o,
    .trap_code_o (code_e),
    .trap_post_o,
    .trap_seg_o,
    .trap_kind_o (tkind_e)
  );

  assign trap_code_o = code_e;
  assign trap_kind_o = tkind_e;

  assert_bound_blocks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_o && trap_code_o == TRAP_BOUND) |-> (!acc_valid_o && !trap_post_o));
  assert_pre_blocks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_o && !trap_post_o) |-> !acc_valid_o);
  assert_post_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_o && trap_post_o) |-> (trap_code_o == TRAP_RIGHT));
  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (!acc_valid_o && !(trap_valid_o && !trap_post_o)));
endmodule

// File: tb/sim_seg_map_unit.sv
module sim_seg_map_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 0, pe_en = 0, req_valid = 0;
  logic [3:0]  ld_idx = 0, pe_idx_a = 0, pe_idx_b = 0, req_seg = 0;
  logic [31:0] ld_data = 0, pe_data_a = 0, pe_data_b = 0;
  logic [15:0] req_off = 0;
  logic [1:0]  req_kind = 0;
  logic        acc_valid, trap_valid, trap_post;
  logic [19:0] phys_addr;
  logic [1:0]  trap_code, trap_kind;
  logic [3:0]  trap_seg;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  seg_map_unit u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ld_en_i(ld_en), .ld_idx_i(ld_idx), .ld_data_i(ld_data),
    .pe_en_i(pe_en), .pe_idx_a_i(pe_idx_a), .pe_data_a_i(pe_data_a),
    .pe_idx_b_i(pe_idx_b), .pe_data_b_i(pe_data_b),
    .req_valid_i(req_valid), .req_seg_i(req_seg), .req_off_i(req_off), .req_kind_i(req_kind),
    .acc_valid_o(acc_valid), .phys_addr_o(phys_addr),
    .trap_valid_o(trap_valid), .trap_code_o(trap_code), .trap_post_o(trap_post),
    .trap_seg_o(trap_seg), .trap_kind_o(trap_kind)
  );

  function automatic logic [31:0] mk(input logic [15:0] base, input logic [11:0] bnd,
                                     input bit r, input bit w, input bit x, input bit post);
    return {post, x, w, r, bnd, base};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic clear_in();
    ld_en = 0; pe_en = 0; req_valid = 0;
  endtask

  task automatic do_load(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk); clear_in();
    ld_en = 1; ld_idx = idx; ld_data = d;
    @(posedge clk); #1 ld_en = 0;
  endtask

  task automatic step_req(input logic [3:0] seg, input logic [15:0] off, input logic [1:0] kind);
    @(negedge clk); clear_in();
    req_valid = 1; req_seg = seg; req_off = off; req_kind = kind;
    #2;
  endtask

  task automatic step_idle();
    @(negedge clk); clear_in();
    #2;
  endtask

  task automatic expect_grant(input string req, input logic [19:0] pa);
    check(req, "acc_valid", acc_valid, 1);
    check(req, "phys", phys_addr, pa);
  endtask

  task automatic expect_trap(input string req, input logic [1:0] code, input bit post,
                             input logic [3:0] seg, input logic [1:0] kind, input bit acc);
    check(req, "trap_valid", trap_valid, 1);
    check(req, "trap_code", trap_code, code);
    check(req, "trap_post", trap_post, post);
    check(req, "trap_seg", trap_seg, seg);
    check(req, "trap_kind", trap_kind, kind);
    check(req, "acc_valid", acc_valid, acc);
  endtask

  task automatic t_reset();
    step_idle();
    check("R1", "acc idle", acc_valid, 0);
    check("R1", "trap idle", trap_valid, 0);
    step_req(4'd0, 16'h0003, 2'd0);
    expect_trap("R1", 2'd2, 0, 4'd0, 2'd0, 0);
  endtask

  task automatic t_addr();
    do_load(4'd3, mk(16'h1234, 12'hFFF, 1, 1, 1, 0));
    step_req(4'd3, 16'hABCD, 2'd0);
    expect_grant("R2", 20'h1CF0D);
    do_load(4'd2, mk(16'hFFFF, 12'hFFF, 1, 1, 1, 0));
    step_req(4'd2, 16'h0020, 2'd1);
    expect_grant("R2 wrap", 20'h00010);
  endtask

  task automatic t_bound();
    do_load(4'd4, mk(16'h0100, 12'h010, 1, 1, 1, 1));
    step_req(4'd4, 16'h010F, 2'd0);
    expect_grant("R3 edge", 20'h0110F);
    check("R3 edge", "no trap", trap_valid, 0);
    step_req(4'd4, 16'h0110, 2'd2);
    expect_trap("R3 over", 2'd1, 0, 4'd4, 2'd2, 0);
    step_idle();
    check("R3", "no late trap", trap_valid, 0);
  endtask

  task automatic t_rights();
    do_load(4'd5, mk(16'h0200, 12'h0FF, 1, 0, 0, 0));
    step_req(4'd5, 16'h0004, 2'd0);
    expect_grant("R4 read", 20'h02004);
    step_req(4'd5, 16'h0004, 2'd1);
    expect_trap("R5 write", 2'd2, 0, 4'd5, 2'd1, 0);
    step_req(4'd5, 16'h0004, 2'd2);
    expect_trap("R5 exec", 2'd2, 0, 4'd5, 2'd2, 0);
    do_load(4'd6, mk(16'h0300, 12'h0FF, 1, 1, 1, 0));
    step_req(4'd6, 16'h0008, 2'd2);
    expect_grant("R4 exec", 20'h03008);
    step_req(4'd6, 16'h0008, 2'd3);
    expect_trap("R4 rsvd", 2'd2, 0, 4'd6, 2'd3, 0);
  endtask

  task automatic t_post();
    do_load(4'd7, mk(16'h0400, 12'h0FF, 1, 0, 0, 1));
    step_req(4'd7, 16'h0010, 2'd1);
    expect_grant("R6 grant", 20'h04010);
    check("R6", "no same-cycle trap", trap_valid, 0);
    step_idle();
    expect_trap("R6 late", 2'd2, 1, 4'd7, 2'd1, 0);
    step_idle();
    check("R6", "trap once", trap_valid, 0);
  endtask

  task automatic t_collide();
    step_req(4'd7, 16'h0020, 2'd2);
    expect_grant("R7 post src", 20'h04020);
    step_req(4'd5, 16'h0000, 2'd1);
    expect_trap("R7 pre wins", 2'd2, 0, 4'd5, 2'd1, 0);
    step_idle();
    expect_trap("R7 deferred", 2'd2, 1, 4'd7, 2'd2, 0);
    step_idle();
    check("R7", "cleared", trap_valid, 0);
  endtask

  task automatic t_load_same();
    do_load(4'd8, mk(16'h0500, 12'h0FF, 1, 0, 0, 0));
    @(negedge clk); clear_in();
    ld_en = 1; ld_idx = 4'd8; ld_data = mk(16'h0600, 12'h0FF, 0, 0, 0, 0);
    req_valid = 1; req_seg = 4'd8; req_off = 16'h0001; req_kind = 2'd0;
    #2;
    expect_grant("R8 old", 20'h05001);
    step_req(4'd8, 16'h0001, 2'd0);
    expect_trap("R8 new", 2'd2, 0, 4'd8, 2'd0, 0);
  endtask

  task automatic t_pe();
    @(negedge clk); clear_in();
    pe_en = 1;
    pe_idx_a = 4'd9;  pe_data_a = mk(16'h0700, 12'h0FF, 1, 0, 0, 0);
    pe_idx_b = 4'd10; pe_data_b = mk(16'h0800, 12'h00F, 1, 1, 0, 0);
    ld_en = 1; ld_idx = 4'd11; ld_data = mk(16'h0900, 12'hFFF, 1, 1, 1, 0);
    req_valid = 1; req_seg = 4'd9; req_off = 16'h0002; req_kind = 2'd0;
    #2;
    expect_trap("R9 old", 2'd2, 0, 4'd9, 2'd0, 0);
    step_req(4'd9, 16'h0002, 2'd0);
    expect_grant("R9 a", 20'h07002);
    step_req(4'd10, 16'h0030, 2'd1);
    expect_grant("R9 b local write", 20'h08030);
    step_req(4'd9, 16'h0030, 2'd1);
    expect_trap("R9 outer no write", 2'd2, 0, 4'd9, 2'd1, 0);
    step_req(4'd11, 16'h0000, 2'd0);
    expect_trap("R9 single ignored", 2'd2, 0, 4'd11, 2'd0, 0);
    @(negedge clk); clear_in();
    pe_en = 1;
    pe_idx_a = 4'd12; pe_data_a = mk(16'h0A00, 12'h0FF, 1, 0, 0, 0);
    pe_idx_b = 4'd12; pe_data_b = mk(16'h0B00, 12'h0FF, 0, 1, 0, 0);
    step_req(4'd12, 16'h0005, 2'd1);
    expect_grant("R9 same idx b", 20'h0B005);
    step_req(4'd12, 16'h0005, 2'd0);
    expect_trap("R9 same idx a lost", 2'd2, 0, 4'd12, 2'd0, 0);
  endtask

  task automatic t_idle();
    @(negedge clk); clear_in();
    req_seg = 4'd0; req_off = 16'hFFFF; req_kind = 2'd3;
    #2;
    check("R10", "acc", acc_valid, 0);
    check("R10", "trap", trap_valid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_addr();
    t_bound();
    t_rights();
    t_post();
    t_collide();
    t_load_same();
    t_pe();
    t_idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule